// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

The block is a watchdog peripheral with two clock domains. A 32-bit register port runs on the bus clock. A 12-bit down-counter runs on a separate low-speed clock, behind a power-of-two prescaler. Software controls the timer only through magic values written to a key register. One value starts the count, one reloads the counter, and one opens the protected configuration registers for writing. Once started, the timer cannot be stopped by software.

The prescaler, reload and early-wake settings are held on the bus side. Each accepted change is sent to the counter domain through a toggle handshake. A status register shows which changes are still in flight. When the counter expires, the block emits a one-cycle reset request on the low-speed clock. If enabled, it raises an early-wake interrupt when the counter passes a programmed value. Two freeze inputs, one for stop mode and one for standby mode, each gated by its own enable pin, hold the counter while the system sleeps.

Top module: `wdg_top`

## Requirements
- R1: After reset, `rst_req_o` and `ew_irq_o` are 0 and the status register reads 0. The prescaler reads 0, the reload reads 0xFFF and the early-wake control reads 0.
- R2: Before the start key 0xCCCC is written to offset 0x00, no reset request is produced.
- R3: Once started, reset requests repeat every (R+1)*D low-speed cycles. R is the reload value (valid from 3 upward, 12 bits at offset 0x08) and D = 4 << min(code, 6), where code is the 4-bit field of the prescaler register at offset 0x04. Code 6 and above divide by 256.
- R4: Writing 0xAAAA to the key register reloads the counter. Refreshing more often than the timeout prevents any reset request. The request follows (R+1)*D cycles after the last refresh, plus a few cycles of synchronizer latency.
- R5: Writes to the prescaler, the reload, or the enable and compare fields of the early-wake register (offset 0x14) are ignored unless the unlock key 0x5555 has been written.
- R6: A key-register write of any value other than 0x5555 locks the protected registers again.
- R7: Status bits at offset 0x0C flag a pending change: bit 0 for the prescaler, bit 1 for the reload, bit 3 for early-wake. A bit is set on the cycle after an accepted write and clears once the counter domain uses the new value. Bit 2 always reads 0. A write to a register whose bit is still set is dropped.
- R8: With early-wake enabled (bit 15), the counter stepping down to the compare value (bits 11:0) raises `ew_irq_o`. Writing 1 to bit 14 clears it, and bit 14 reads back the pending flag. With bit 15 at 0, the interrupt output stays low.
- R9: While `stop_i` is high with `stop_frz_en_i` set, or `standby_i` is high with `stby_frz_en_i` set, the counter and prescaler hold. A freeze input whose enable pin is 0 has no effect.
- R10: Once started, no key or register write stops the count.
- R11: Each reset request lasts exactly one low-speed clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| clk_lp_i | input | 1 | Low-speed counter clock |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| stop_i | input | 1 | System is in stop mode |
| standby_i | input | 1 | System is in standby mode |
| stop_frz_en_i | input | 1 | Allow stop mode to freeze the counter |
| stby_frz_en_i | input | 1 | Allow standby mode to freeze the counter |
| rst_req_o | output | 1 | Reset request pulse, low-speed domain |
| ew_irq_o | output | 1 | Early-wake interrupt, bus domain |

## Verification
A wrong divider or reload value in the counter domain appears at `rst_req_o` as a wrong spacing between requests, off by a whole multiple of D, as soon as the second request after the change. So the bench sweeps reload values and prescaler codes and compares intervals with the arithmetic period. A stuck handshake bit shows as a status bit that never clears within a few dozen bus cycles. A broken lock or freeze shows as a readback or a pulse interval that differs from the computed one within a single period.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [15:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [15:0] KEY_START   = 16'hCCCC;

  localparam int OFS_KEY  = 'h00;
  localparam int OFS_PRE  = 'h04;
  localparam int OFS_RLD  = 'h08;
  localparam int OFS_STAT = 'h0C;
  localparam int OFS_EWC  = 'h14;

  // handshake lane per protected setting
  localparam int HS_PRE = 0;
  localparam int HS_RLD = 1;
  localparam int HS_EW  = 2;
  localparam int HS_N   = 3;

  localparam int EW_IE_BIT  = 15;
  localparam int EW_CLR_BIT = 14;
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [HS_N-1:0]   ack_tgl_i,
  input  logic              ew_tgl_i,
  output logic [PRE_W-1:0]  pre_o,
  output logic [CNT_W-1:0]  rld_o,
  output logic [CNT_W-1:0]  ewc_o,
  output logic [HS_N-1:0]   req_tgl_o,
  output logic              run_o,
  output logic              rfr_tgl_o,
  output logic              ew_irq_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] rld_q, ewc_q;
  logic [HS_N-1:0]  req_q, pend;
  logic             unlock_q, run_q, rfr_q, ew_ie_q, ew_flag_q, ew_d_q;
  logic             wr, key_wr, pre_wr, rld_wr, ew_wr;
  logic [15:0]      key;
  logic             unused_wdata;

  assign wr     = bus_req_i & bus_we_i;
  assign key_wr = wr && bus_addr_i == ADDR_W'(OFS_KEY);
  assign pre_wr = wr && bus_addr_i == ADDR_W'(OFS_PRE);
  assign rld_wr = wr && bus_addr_i == ADDR_W'(OFS_RLD);
  assign ew_wr  = wr && bus_addr_i == ADDR_W'(OFS_EWC);
  assign key    = bus_wdata_i[15:0];
  assign pend   = req_q ^ ack_tgl_i;
  assign unused_wdata = ^bus_wdata_i[31:16];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      rld_q     <= '1;
      ewc_q     <= '0;
      req_q     <= '0;
      unlock_q  <= 1'b0;
      run_q     <= 1'b0;
      rfr_q     <= 1'b0;
      ew_ie_q   <= 1'b0;
      ew_flag_q <= 1'b0;
      ew_d_q    <= 1'b0;
    end else begin
      ew_d_q <= ew_tgl_i;
      if (key_wr) begin
        unlock_q <= (key == KEY_UNLOCK);
        if (key == KEY_START)   run_q <= 1'b1;
        if (key == KEY_REFRESH) rfr_q <= ~rfr_q;
      end
      if (pre_wr && unlock_q && !pend[HS_PRE]) begin
        pre_q         <= bus_wdata_i[PRE_W-1:0];
        req_q[HS_PRE] <= ~req_q[HS_PRE];
      end
      if (rld_wr && unlock_q && !pend[HS_RLD]) begin
        rld_q         <= bus_wdata_i[CNT_W-1:0];
        req_q[HS_RLD] <= ~req_q[HS_RLD];
      end
      if (ew_wr && unlock_q && !pend[HS_EW]) begin
        ewc_q        <= bus_wdata_i[CNT_W-1:0];
        ew_ie_q      <= bus_wdata_i[EW_IE_BIT];
        req_q[HS_EW] <= ~req_q[HS_EW];
      end
      if (ew_wr && bus_wdata_i[EW_CLR_BIT]) ew_flag_q <= 1'b0;
      if (ew_tgl_i != ew_d_q)               ew_flag_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFS_PRE)) begin
      bus_rdata_o[PRE_W-1:0] = pre_q;
    end else if (bus_addr_i == ADDR_W'(OFS_RLD)) begin
      bus_rdata_o[CNT_W-1:0] = rld_q;
    end else if (bus_addr_i == ADDR_W'(OFS_STAT)) begin
      bus_rdata_o[0] = pend[HS_PRE];
      bus_rdata_o[1] = pend[HS_RLD];
      bus_rdata_o[3] = pend[HS_EW];
    end else if (bus_addr_i == ADDR_W'(OFS_EWC)) begin
      bus_rdata_o[CNT_W-1:0]  = ewc_q;
      bus_rdata_o[EW_CLR_BIT] = ew_flag_q;
      bus_rdata_o[EW_IE_BIT]  = ew_ie_q;
    end
  end

  assign pre_o     = pre_q;
  assign rld_o     = rld_q;
  assign ewc_o     = ewc_q;
  assign req_tgl_o = req_q;
  assign run_o     = run_q;
  assign rfr_tgl_o = rfr_q;
  assign ew_irq_o  = ew_flag_q & ew_ie_q;

  assert_locked_pre_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_wr && !unlock_q) |=> $stable(pre_q));
  assert_locked_rld_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rld_wr && !unlock_q) |=> $stable(rld_q));
  assert_relock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && key != KEY_UNLOCK) |=> !unlock_q);
  assert_pend_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rld_wr && pend[HS_RLD]) |=> $stable(rld_q));
  assert_run_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [CNT_W-1:0] rld_i,
  input  logic [CNT_W-1:0] ewc_i,
  input  logic [HS_N-1:0]  req_tgl_i,
  input  logic             run_i,
  input  logic             rfr_tgl_i,
  input  logic             frz_i,
  output logic [HS_N-1:0]  ack_tgl_o,
  output logic             ew_tgl_o,
  output logic             rst_req_o
);
  localparam int DIV_W = PRE_MAX + 2;

  logic [PRE_W-1:0] pre_act;
  logic [CNT_W-1:0] rld_act, ewc_act, cnt_q;
  logic [DIV_W-1:0] div_q, lim;
  logic [HS_N-1:0]  req_d_q, cap;
  logic             run_d_q, rfr_d_q, ew_q, req_q;
  logic             start_evt, rfr_evt, tick;

  function automatic logic [DIV_W-1:0] div_limit(input logic [PRE_W-1:0] code);
    int eff;
    eff = (int'(code) > PRE_MAX) ? PRE_MAX : int'(code);
    return DIV_W'((32'd1 << (eff + 2)) - 32'd1);
  endfunction

  assign cap       = req_tgl_i ^ req_d_q;
  assign lim       = div_limit(pre_act);
  assign start_evt = run_i & ~run_d_q;
  assign rfr_evt   = run_d_q & (rfr_tgl_i ^ rfr_d_q);
  assign tick      = run_d_q & ~frz_i & (div_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_act <= '0;
      rld_act <= '1;
      ewc_act <= '0;
      req_d_q <= '0;
    end else begin
      req_d_q <= req_tgl_i;
      if (cap[HS_PRE]) pre_act <= pre_i;
      if (cap[HS_RLD]) rld_act <= rld_i;
      if (cap[HS_EW])  ewc_act <= ewc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      div_q   <= '0;
      run_d_q <= 1'b0;
      rfr_d_q <= 1'b0;
      ew_q    <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      run_d_q <= run_i;
      rfr_d_q <= rfr_tgl_i;
      req_q   <= 1'b0;
      if (start_evt || rfr_evt) begin
        cnt_q <= rld_act;
        div_q <= '0;
      end else if (run_d_q && !frz_i) begin
        if (tick) begin
          div_q <= '0;
          if (cnt_q == '0) begin
            cnt_q <= rld_act;
            req_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q - 1'b1 == ewc_act) ew_q <= ~ew_q;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign ack_tgl_o = req_d_q;
  assign ew_tgl_o  = ew_q;
  assign rst_req_o = req_q;

  assert_pulse_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !req_q);
  assert_freeze_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_d_q && frz_i && !rfr_evt) |=> ($stable(cnt_q) && $stable(div_q)));
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 6,
  parameter int ADDR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_lp_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              stop_i,
  input  logic              standby_i,
  input  logic              stop_frz_en_i,
  input  logic              stby_frz_en_i,
  output logic              rst_req_o,
  output logic              ew_irq_o
);
  localparam int LP_W  = HS_N + 3;
  localparam int BUS_W = HS_N + 1;

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] rld, ewc;
  logic [HS_N-1:0]  req_tgl, req_tgl_s, ack_tgl, ack_tgl_s;
  logic             run, run_s, rfr_tgl, rfr_tgl_s, frz_raw, frz_s, ew_tgl, ew_tgl_s;

  assign frz_raw = (stop_i & stop_frz_en_i) | (standby_i & stby_frz_en_i);

  wdg_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .ack_tgl_i(ack_tgl_s), .ew_tgl_i(ew_tgl_s),
    .pre_o(pre), .rld_o(rld), .ewc_o(ewc), .req_tgl_o(req_tgl),
    .run_o(run), .rfr_tgl_o(rfr_tgl), .ew_irq_o
  );

  wdg_sync #(.W(LP_W)) u_sync_lp (
    .clk_i(clk_lp_i), .rst_ni,
    .d_i({req_tgl, run, rfr_tgl, frz_raw}),
    .q_o({req_tgl_s, run_s, rfr_tgl_s, frz_s})
  );

  wdg_sync #(.W(BUS_W)) u_sync_bus (
    .clk_i, .rst_ni,
    .d_i({ack_tgl, ew_tgl}),
    .q_o({ack_tgl_s, ew_tgl_s})
  );

  wdg_core #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_core (
    .clk_i(clk_lp_i), .rst_ni,
    .pre_i(pre), .rld_i(rld), .ewc_i(ewc),
    .req_tgl_i(req_tgl_s), .run_i(run_s), .rfr_tgl_i(rfr_tgl_s), .frz_i(frz_s),
    .ack_tgl_o(ack_tgl), .ew_tgl_o(ew_tgl), .rst_req_o
  );
endmodule

// File: tb/sim_wdg_top.sv
module sim_wdg_top;
  import wdg_pkg::*;

  logic        clk = 1'b0, clk_lp = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        stop = 1'b0, stby = 1'b0, stop_en = 1'b0, stby_en = 1'b0;
  logic        rst_req, irq;

  int lp_cyc = 0;
  int n_chk = 0, n_fail = 0;

  always #4ns  clk    = ~clk;
  always #20ns clk_lp = ~clk_lp;
  always @(posedge clk_lp) lp_cyc <= lp_cyc + 1;

  wdg_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .clk_lp_i(clk_lp),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .stop_i(stop), .standby_i(stby), .stop_frz_en_i(stop_en), .stby_frz_en_i(stby_en),
    .rst_req_o(rst_req), .ew_irq_o(irq)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 5'(a); req = 1'b1; we = 1'b0;
    #1ns d = rdata;
    req = 1'b0;
  endtask

  task automatic wait_idle(output logic [31:0] st);
    for (int i = 0; i < 60; i++) begin
      bus_rd(OFS_STAT, st);
      if (st == 0) break;
    end
  endtask

  // returns lp cycle of pulse or -1; checks one-cycle width
  task automatic wait_pulse(input int lim, output int at);
    at = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk_lp);
      if (rst_req) begin
        at = lp_cyc;
        @(negedge clk_lp);
        chk(!rst_req, "R11 pulse width", rst_req, 0);
        break;
      end
    end
  endtask

  task automatic watch(input int n, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_lp);
      if (rst_req) seen = 1'b1;
    end
  endtask

  function automatic int div_of(input int code);
    return 4 << ((code > 6) ? 6 : code);
  endfunction

  task automatic config_run(input int code, input int r);
    logic [31:0] st;
    bus_wr(OFS_KEY, 32'(KEY_UNLOCK));
    bus_wr(OFS_PRE, 32'(code));
    bus_wr(OFS_RLD, 32'(r));
    wait_idle(st);
    chk(st == 0, "R7 status clears", st, 0);
  endtask

  initial begin
    #1_300_000ns;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int p0, p1, p2, exp, t0;
    bit seen;
    int codes[5] = '{0, 1, 2, 6, 9};

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(!rst_req, "R1 rst_req", rst_req, 0);
    chk(!irq, "R1 irq", irq, 0);
    bus_rd(OFS_PRE, v);  chk(v == 0, "R1 prescaler", v, 0);
    bus_rd(OFS_RLD, v);  chk(v == 32'hFFF, "R1 reload", v, 32'hFFF);
    bus_rd(OFS_STAT, v); chk(v == 0, "R1 status", v, 0);
    bus_rd(OFS_EWC, v);  chk(v == 0, "R1 early-wake", v, 0);

    // R5 locked writes ignored
    bus_wr(OFS_PRE, 3);
    bus_wr(OFS_RLD, 10);
    bus_wr(OFS_EWC, 32'h8005);
    bus_rd(OFS_PRE, v);  chk(v == 0, "R5 prescaler locked", v, 0);
    bus_rd(OFS_RLD, v);  chk(v == 32'hFFF, "R5 reload locked", v, 32'hFFF);
    bus_rd(OFS_EWC, v);  chk(v == 0, "R5 early-wake locked", v, 0);
    bus_rd(OFS_STAT, v); chk(v == 0, "R5 no pending", v, 0);

    // R6 relock by other key
    bus_wr(OFS_KEY, 32'(KEY_UNLOCK));
    bus_wr(OFS_KEY, 32'h1234);
    bus_wr(OFS_PRE, 2);
    bus_rd(OFS_PRE, v);  chk(v == 0, "R6 relocked", v, 0);

    // R7 pending flags and dropped write
    bus_wr(OFS_KEY, 32'(KEY_UNLOCK));
    bus_wr(OFS_PRE, 1);
    bus_rd(OFS_STAT, v); chk(v == 32'h1, "R7 pre pending", v, 1);
    bus_wr(OFS_PRE, 2);
    bus_wr(OFS_RLD, 5);
    bus_rd(OFS_STAT, v); chk(v[1] == 1'b1 && v[2] == 1'b0, "R7 rld pending, bit2 zero", v, 3);
    wait_idle(v);        chk(v == 0, "R7 clears", v, 0);
    bus_rd(OFS_PRE, v);  chk(v == 1, "R7 write while pending dropped", v, 1);
    bus_rd(OFS_RLD, v);  chk(v == 5, "R7 reload applied", v, 5);

    // R2 no pulse before start
    watch(200, seen);
    chk(!seen, "R2 idle before start", seen, 0);

    bus_wr(OFS_KEY, 32'(KEY_START));

    // R3 sweep of prescaler codes and reload values
    for (int ci = 0; ci < 5; ci++) begin
      for (int r = 3; r <= ((codes[ci] < 3) ? 7 : 3); r++) begin
        config_run(codes[ci], r);
        exp = (r + 1) * div_of(codes[ci]);
        wait_pulse(4000, p0);
        wait_pulse(4000, p1);
        wait_pulse(4000, p2);
        chk(p0 >= 0 && p1 >= 0 && p2 - p1 == exp, $sformatf("R3 period code=%0d r=%0d", codes[ci], r),
            p2 - p1, exp);
      end
    end

    // R4 refresh holds off the request
    config_run(0, 20);
    wait_pulse(400, p0);
    seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      bit s;
      bus_wr(OFS_KEY, 32'(KEY_REFRESH));
      watch(40, s);
      seen |= s;
    end
    chk(!seen, "R4 refresh prevents request", seen, 0);
    bus_wr(OFS_KEY, 32'(KEY_REFRESH));
    t0 = lp_cyc;
    wait_pulse(400, p1);
    chk(p1 - t0 >= 84 && p1 - t0 <= 90, "R4 request after last refresh", p1 - t0, 84);

    // R10 cannot be stopped
    bus_wr(OFS_KEY, 32'h0000);
    bus_wr(OFS_KEY, 32'hFFFF);
    bus_wr(OFS_KEY, 32'(KEY_UNLOCK));
    bus_wr(OFS_KEY, 32'h0);
    wait_pulse(400, p1);
    wait_pulse(400, p2);
    chk(p1 >= 0 && p2 - p1 == 84, "R10 still running", p2 - p1, 84);

    // R9 freeze gated by enable
    stop_en = 1'b1;
    wait_pulse(400, p0);
    stop = 1'b1;
    repeat (300) @(negedge clk_lp);
    stop = 1'b0;
    wait_pulse(800, p1);
    chk(p1 - p0 >= 381 && p1 - p0 <= 387, "R9 stop freeze", p1 - p0, 384);
    stop_en = 1'b0; stby_en = 1'b1;
    wait_pulse(400, p0);
    stby = 1'b1;
    repeat (200) @(negedge clk_lp);
    stby = 1'b0;
    wait_pulse(800, p1);
    chk(p1 - p0 >= 281 && p1 - p0 <= 287, "R9 standby freeze", p1 - p0, 284);
    stby_en = 1'b0;
    wait_pulse(400, p0);
    stop = 1'b1; stby = 1'b1;
    wait_pulse(400, p1);
    stop = 1'b0; stby = 1'b0;
    chk(p1 - p0 == 84, "R9 disabled freeze no effect", p1 - p0, 84);

    // R8 early-wake interrupt
    bus_wr(OFS_KEY, 32'(KEY_UNLOCK));
    bus_wr(OFS_EWC, 32'h800A);
    bus_rd(OFS_STAT, v); chk(v == 32'h8, "R8/R7 ew pending", v, 8);
    wait_idle(v);
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1'b1; break; end
    end
    if (!seen) begin
      for (int i = 0; i < 100; i++) begin
        @(negedge clk_lp);
        if (irq) begin seen = 1'b1; break; end
      end
    end
    chk(seen, "R8 irq raised", seen, 1);
    bus_rd(OFS_EWC, v);  chk(v == 32'hC00A, "R8 flag readback", v, 32'hC00A);
    bus_wr(OFS_EWC, 32'h4000);
    @(negedge clk);
    chk(!irq, "R8 irq cleared", irq, 0);
    bus_wr(OFS_KEY, 32'(KEY_UNLOCK));
    bus_wr(OFS_EWC, 32'h400A);
    wait_idle(v);
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_lp);
      if (irq) seen = 1'b1;
    end
    chk(!seen, "R8 disabled irq stays low", seen, 0);
    bus_rd(OFS_EWC, v);  chk(v[14] == 1'b1, "R8 flag still latched", v[14], 1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule